// File: doc/BRIEF.md
# Dispatch Group Slot Gate

This block sits beside the decoder of a superscalar front end and decides, every cycle, whether the decoded candidate instruction may join the dispatch group being built. A candidate carries a valid bit, a three-bit unit class, and four flags: first-only, single, cracked, and a pair of count-register flags (one marks a count-register write, the other a branch through the count register). From the number of slots already used and the flags, the block produces a two-bit verdict. The verdict can be clear, hazard (the group must close first) or noop-needed (a filler slot must be spent before the candidate is safe). The verdict is combinational, so the issue logic can act on it in the same cycle.

An `accept` strobe commits the candidate and advances the slot count. An `advance` strobe spends one slot as a no-op. The block is a two-state machine. In state `GRP_OPEN` it collects slots. When the count reaches five, the transition `FILL_DONE` moves it to `GRP_CLOSING`. That state lasts one cycle, in which `group_end` is high and the count reads five. The transition `RESTART` then returns it to `GRP_OPEN` with a zero count and a cleared count-register flag. In `GRP_CLOSING` every real candidate is refused, and an `advance` raises `adv_err` and has no effect.

Top module: `dgrp_gate`

## Requirements
- R1: After reset `slot_count` is 0 and `group_end` and `adv_err` are low. The verdict encoding is 2'b00 clear, 2'b01 hazard and 2'b10 noop-needed, and an invalid candidate always gets 2'b00.
- R2: Unit class 3'd0 is a pseudo-instruction. It always gets verdict 2'b00, and accepting it changes no state. Accepting an invalid candidate also changes no state.
- R3: A candidate with the first-only or the single flag gets 2'b01 whenever `slot_count` is not 0.
- R4: A cracked candidate gets 2'b01 when `slot_count` is above 2. An accepted cracked instruction adds 2 to the count.
- R5: Unit classes 3'd1 to 3'd5 (fixed-point, load/store, floating-point, vector ALU, vector permute) get 2'b01 at `slot_count` 4. The branch class 3'd7 gets 2'b00 at count 4.
- R6: The condition-register class 3'd6 gets 2'b01 when `slot_count` is 2 or more.
- R7: Accepting a branch or a single instruction sets `slot_count` to 5 on the next cycle.
- R8: When the count reaches 5, `group_end` is high for exactly that one cycle and every valid non-pseudo candidate gets 2'b01. On the following cycle the count is 0 and the count-register flag is clear.
- R9: Accepting a candidate with `cand_ctr_wr` set raises the count-register flag. While the flag is set, a candidate with `cand_ctr_br` that meets no slot rule gets 2'b10. Slot hazards take precedence over 2'b10.
- R10: `advance` with `accept` low adds one to the count. When `accept` is high, `advance` is ignored.
- R11: `advance` with `accept` low while the count is 5 drives `adv_err` high in that cycle, and the count still restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate present |
| cand_unit | input | 3 | Unit class of the candidate |
| cand_first | input | 1 | Candidate must take the first slot |
| cand_single | input | 1 | Candidate occupies a whole group |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_ctr_wr | input | 1 | Candidate writes the count register |
| cand_ctr_br | input | 1 | Candidate branches through the count register |
| accept | input | 1 | Commit the candidate this cycle |
| advance | input | 1 | Spend one slot as a no-op |
| verdict | output | 2 | 00 clear, 01 hazard, 10 noop-needed |
| slot_count | output | 3 | Slots used in the current group |
| group_end | output | 1 | One-cycle pulse when the group is complete |
| adv_err | output | 1 | Advance requested on a full group |

## Verification
Several properties are checked on every cycle by assertions: the count never exceeds five, `group_end` never lasts two cycles, the closing state always restarts cleanly, pseudo and invalid commits leave the count untouched, and late first-only candidates are always refused. Other behaviour only shows up in the bench's directed sequences. This covers the exact slot arithmetic for cracked and group-closing instructions, the class-specific thresholds, the priority of slot hazards over the noop verdict, and the clearing of the count-register flag across a group boundary.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;
    typedef enum logic [2:0] {
        U_PSEUDO = 3'd0,
        U_INT    = 3'd1,
        U_MEM    = 3'd2,
        U_FLT    = 3'd3,
        U_VEC    = 3'd4,
        U_VPRM   = 3'd5,
        U_CREG   = 3'd6,
        U_BR     = 3'd7
    } unit_e;

    typedef enum logic [1:0] {
        V_CLEAR = 2'b00,
        V_HAZ   = 2'b01,
        V_NOOP  = 2'b10
    } verdict_e;

    typedef enum logic {
        GRP_OPEN    = 1'b0,
        GRP_CLOSING = 1'b1
    } grp_state_e;
endpackage

// File: rtl/dgrp_verdict.sv
module dgrp_verdict
    import dgrp_pkg::*;
#(
    parameter int SLOTS     = 5,
    parameter int CRACK_MAX = 2,
    parameter int CREG_MAX  = 2,
    localparam int CW       = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  unit_e         unit,
    input  logic          first,
    input  logic          single,
    input  logic          cracked,
    input  logic          ctr_br,
    input  logic [CW-1:0] cnt,
    input  logic          full,
    input  logic          ctr_flag,
    output verdict_e      verdict
);
    logic slot_haz;
    logic real_op;

    assign real_op = valid && (unit != U_PSEUDO);

    always_comb begin
        slot_haz = full;
        if ((first || single) && (cnt != '0))
            slot_haz = 1'b1;
        if (cracked && (cnt > CW'(CRACK_MAX)))
            slot_haz = 1'b1;
        unique case (unit)
            U_INT, U_MEM, U_FLT, U_VEC, U_VPRM:
                if (cnt == CW'(SLOTS - 1)) slot_haz = 1'b1;
            U_CREG:
                if (cnt >= CW'(CREG_MAX)) slot_haz = 1'b1;
            U_BR, U_PSEUDO: ;
            default: ;
        endcase
    end

    always_comb begin
        if (!real_op)
            verdict = V_CLEAR;
        else if (slot_haz)
            verdict = V_HAZ;
        else if (ctr_flag && ctr_br)
            verdict = V_NOOP;
        else
            verdict = V_CLEAR;
    end

    assert_pseudo_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || unit == U_PSEUDO) |-> verdict == V_CLEAR);
    assert_late_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (real_op && (first || single) && cnt != '0) |-> verdict == V_HAZ);
    assert_noop_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == V_NOOP) |-> (ctr_flag && ctr_br));
endmodule

// File: rtl/dgrp_track.sv
module dgrp_track
    import dgrp_pkg::*;
#(
    parameter int SLOTS = 5,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  unit_e         unit,
    input  logic          single,
    input  logic          cracked,
    input  logic          ctr_wr,
    input  logic          accept,
    input  logic          advance,
    output logic [CW-1:0] cnt,
    output logic          ctr_flag,
    output logic          full,
    output logic          group_end,
    output logic          adv_err
);
    grp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic          flag_d;
    logic          take, step;
    logic [CW:0]   base, sum;

    assign take = accept && valid && (unit != U_PSEUDO) && (state_q == GRP_OPEN);
    assign step = advance && !accept && (state_q == GRP_OPEN);

    always_comb begin
        base = (unit == U_BR || single) ? (CW+1)'(SLOTS - 1) : {1'b0, cnt};
        sum  = base + (cracked ? (CW+1)'(2) : (CW+1)'(1));
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        flag_d  = ctr_flag;
        unique case (state_q)
            GRP_OPEN: begin
                if (take) begin
                    cnt_d = (sum >= (CW+1)'(SLOTS)) ? CW'(SLOTS) : sum[CW-1:0];
                    if (ctr_wr) flag_d = 1'b1;
                end else if (step) begin
                    cnt_d = cnt + CW'(1);
                end
                if (cnt_d == CW'(SLOTS))
                    state_d = GRP_CLOSING;          // FILL_DONE
            end
            GRP_CLOSING: begin
                state_d = GRP_OPEN;                 // RESTART
                cnt_d   = '0;
                flag_d  = 1'b0;
            end
            default: state_d = GRP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= GRP_OPEN;
            cnt      <= '0;
            ctr_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt      <= cnt_d;
            ctr_flag <= flag_d;
        end
    end

    always_comb begin
        full      = (state_q == GRP_CLOSING);
        group_end = (state_q == GRP_CLOSING);
        adv_err   = advance && !accept && (state_q == GRP_CLOSING);
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(SLOTS));
    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        group_end |=> !group_end);
    assert_restart_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        group_end |=> (cnt == '0 && !ctr_flag));
    assert_idle_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_OPEN && accept && (!valid || unit == U_PSEUDO)) |=> $stable(cnt));
endmodule

// File: rtl/dgrp_gate.sv
module dgrp_gate #(
    parameter int SLOTS     = 5,
    parameter int CRACK_MAX = 2,
    parameter int CREG_MAX  = 2,
    localparam int CW       = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_valid,
    input  logic [2:0]    cand_unit,
    input  logic          cand_first,
    input  logic          cand_single,
    input  logic          cand_cracked,
    input  logic          cand_ctr_wr,
    input  logic          cand_ctr_br,
    input  logic          accept,
    input  logic          advance,
    output logic [1:0]    verdict,
    output logic [CW-1:0] slot_count,
    output logic          group_end,
    output logic          adv_err
);
    import dgrp_pkg::*;

    unit_e    unit;
    verdict_e vd;
    logic     full;
    logic     ctr_flag;

    assign unit    = unit_e'(cand_unit);
    assign verdict = vd;

    dgrp_track #(.SLOTS(SLOTS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (cand_valid),
        .unit      (unit),
        .single    (cand_single),
        .cracked   (cand_cracked),
        .ctr_wr    (cand_ctr_wr),
        .accept    (accept),
        .advance   (advance),
        .cnt       (slot_count),
        .ctr_flag  (ctr_flag),
        .full      (full),
        .group_end (group_end),
        .adv_err   (adv_err)
    );

    dgrp_verdict #(.SLOTS(SLOTS), .CRACK_MAX(CRACK_MAX), .CREG_MAX(CREG_MAX)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (cand_valid),
        .unit     (unit),
        .first    (cand_first),
        .single   (cand_single),
        .cracked  (cand_cracked),
        .ctr_br   (cand_ctr_br),
        .cnt      (slot_count),
        .full     (full),
        .ctr_flag (ctr_flag),
        .verdict  (vd)
    );
endmodule

// File: tb/test_dgrp_gate.sv
module test_dgrp_gate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cand_valid = 1'b0;
    logic [2:0] cand_unit = 3'd0;
    logic       cand_first = 1'b0, cand_single = 1'b0, cand_cracked = 1'b0;
    logic       cand_ctr_wr = 1'b0, cand_ctr_br = 1'b0;
    logic       accept = 1'b0, advance = 1'b0;
    logic [1:0] verdict;
    logic [2:0] slot_count;
    logic       group_end, adv_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dgrp_gate i_dgrp_gate (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
        .cand_first(cand_first), .cand_single(cand_single), .cand_cracked(cand_cracked),
        .cand_ctr_wr(cand_ctr_wr), .cand_ctr_br(cand_ctr_br), .accept(accept),
        .advance(advance), .verdict(verdict), .slot_count(slot_count),
        .group_end(group_end), .adv_err(adv_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a candidate at the falling edge, let the verdict settle
    task automatic put(input bit v, input int u, input bit f, input bit s, input bit c,
                       input bit wr, input bit br, input bit acc, input bit adv);
        @(negedge clk);
        cand_valid = v; cand_unit = 3'(u); cand_first = f; cand_single = s;
        cand_cracked = c; cand_ctr_wr = wr; cand_ctr_br = br;
        accept = acc; advance = adv;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cand_valid = 0; cand_unit = 0; cand_first = 0; cand_single = 0;
        cand_cracked = 0; cand_ctr_wr = 0; cand_ctr_br = 0; accept = 0; advance = 0;
    endtask

    task automatic commit(input int u, input bit s, input bit c, input bit wr);
        put(1, u, 0, s, c, wr, 0, 1, 0);
        tick();
    endtask

    task automatic drain();
        while (slot_count != 0 || group_end) begin
            put(0, 0, 0, 0, 0, 0, 0, 0, !group_end);
            tick();
        end
    endtask

    task automatic t_reset();
        chk("R1 count", slot_count, 0);
        chk("R1 group_end", group_end, 0);
        chk("R1 adv_err", adv_err, 0);
        put(0, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R1 invalid verdict", verdict, 0);
        tick();
    endtask

    task automatic t_pseudo();
        commit(1, 0, 0, 0);
        put(1, 0, 1, 1, 1, 0, 0, 1, 0);
        chk("R2 pseudo verdict", verdict, 0);
        tick();
        chk("R2 pseudo no change", slot_count, 1);
        put(0, 1, 0, 0, 0, 0, 0, 1, 0);
        tick();
        chk("R2 invalid no change", slot_count, 1);
        drain();
    endtask

    task automatic t_first_and_advance();
        commit(1, 0, 0, 0);
        put(1, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R3 first late", verdict, 1);
        put(1, 7, 0, 1, 0, 0, 0, 0, 0);
        chk("R3 single late", verdict, 1);
        put(0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R10 advance", slot_count, 2);
        put(1, 1, 0, 0, 0, 0, 0, 1, 1); tick();
        chk("R10 advance ignored with accept", slot_count, 3);
        put(1, 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 cracked at 3", verdict, 1);
        put(0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        put(0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        chk("R8 count five", slot_count, 5);
        chk("R8 group_end", group_end, 1);
        tick();
        chk("R8 restart", slot_count, 0);
        chk("R8 pulse one cycle", group_end, 0);
    endtask

    task automatic t_cracked_branch();
        put(1, 2, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 cracked at 0", verdict, 0);
        commit(2, 0, 1, 0);
        chk("R4 cracked adds two", slot_count, 2);
        put(1, 3, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 cracked at 2", verdict, 0);
        commit(3, 0, 1, 0);
        chk("R4 second cracked", slot_count, 4);
        put(1, 4, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 vector at 4", verdict, 1);
        put(1, 5, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 permute at 4", verdict, 1);
        put(1, 7, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 branch at 4", verdict, 0);
        tick();
        commit(7, 0, 0, 0);
        chk("R7 branch closes", slot_count, 5);
        put(1, 7, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 full refuses", verdict, 1);
        chk("R11 adv_err", adv_err, 1);
        tick();
        chk("R11 restart after err", slot_count, 0);
    endtask

    task automatic t_creg_single();
        put(1, 6, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 cr at 0", verdict, 0);
        tick();
        commit(1, 0, 0, 0);
        put(1, 6, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 cr at 1", verdict, 0);
        tick();
        commit(1, 0, 0, 0);
        put(1, 6, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 cr at 2", verdict, 1);
        tick();
        drain();
        commit(1, 1, 0, 0);
        chk("R7 single closes", slot_count, 5);
        tick();
    endtask

    task automatic t_ctr();
        commit(1, 0, 0, 1);
        put(1, 7, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 noop verdict", verdict, 2);
        tick();
        commit(1, 0, 0, 0);
        commit(1, 0, 0, 0);
        commit(1, 0, 0, 0);
        put(1, 1, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 hazard precedes noop", verdict, 1);
        tick();
        drain();
        put(1, 7, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 flag cleared by group end", verdict, 0);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pseudo();
        t_first_and_advance();
        t_cracked_branch();
        t_creg_single();
        t_ctr();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule